// File: doc/BRIEF.md
# Timer Trigger Output Generator

This block is a small up-counting timer whose only job towards the rest of the chip is one trigger line, `trig_o`, meant to start, gate or clock a second timer. The counter runs from zero up to a programmable reload value and then wraps. The wrap, a software-forced restart, the enable state, a channel-1 match pulse and four compare reference levels can each drive the trigger line, and a 3-bit source selector picks which one.

An external trigger pin can also drive the timer. It first passes a two-stage synchroniser, and a polarity bit can invert it. In gated slave mode the conditioned level enables counting. In reset slave mode its rising edge restarts the counter. An alignment bit adds one cycle of delay on the conditioned trigger inside the timer. With that delay, the enable the timer presents on `trig_o` and the timer's own counting begin in the same cycle.

All configuration arrives as plain register-style input levels. The trigger line comes out of a flop, so it is clean and one cycle behind the event it reports.

Top module: `tmr_sync_out`

## Requirements
- R1: While `rst_ni` is low, `cnt_o` is 0 and `trig_o` is 0. The synchroniser, alignment and edge flops are also cleared.
- R2: The counter advances by one on each clock edge where it is enabled, either by `sw_en_i` or by the gated trigger. On the edge after it reaches `arr_i` it returns to 0. It holds its value when it is not enabled.
- R3: A high `sw_ug_i` clears the counter on the next edge. This clear wins over counting.
- R4: `trig_o` is a flop that takes the selected source one cycle later. With `mst_sel_i` = 0 the source is the restart event: `sw_ug_i`, or a reset-mode trigger edge. After a trigger-edge restart, `trig_o` rises on the same edge that clears the counter.
- R5: With `mst_sel_i` = 1 the source is the counter enable. It is high in every cycle where counting is enabled.
- R6: With `mst_sel_i` = 2 the source is the update event. It is high for one cycle after the enabled cycle in which the counter equals `arr_i`.
- R7: With `mst_sel_i` = 3, `trig_o` gives a one-cycle pulse after every enabled cycle in which the counter equals `cmp_i[0]`. This includes every repeated match on later wraps.
- R8: With `mst_sel_i` = 4, 5, 6 or 7 the source is the reference level of channel 1, 2, 3 or 4. A channel's reference is high while the counter is below `cmp_i[k]`, where k is the channel number minus 1.
- R9: With `ext_pol_i` = 0, `ext_trig_i` is active high and its rising edge is the trigger edge. With `ext_pol_i` = 1 it is active low and its falling edge is the trigger edge.
- R10: In gated mode (`slv_mode_i` = 1) with `align_i` = 0, an active pin level set before clock edge E1 makes the first increment happen on edge E3. `trig_o` rises on edge E3 in mode 1.
- R11: In reset mode (`slv_mode_i` = 2), a trigger edge set up before E1 clears the counter on E3. A level that stays active causes no further clears.
- R12: In gated mode with `align_i` = 1, `trig_o` still rises on E3 in mode 1. The first increment moves to E4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_en_i | input | 1 | Software counter enable |
| sw_ug_i | input | 1 | Software restart / update request |
| arr_i | input | 16 | Auto-reload (terminal count) value |
| cmp_i | input | 4x16 | Compare values; `cmp_i[k]` belongs to channel k+1 |
| mst_sel_i | input | 3 | Trigger output source select |
| slv_mode_i | input | 2 | 0 none, 1 gated, 2 reset, 3 none |
| ext_pol_i | input | 1 | External trigger polarity (1 inverts) |
| align_i | input | 1 | Delay the trigger input to line up with the trigger output |
| ext_trig_i | input | 1 | External trigger pin |
| trig_o | output | 1 | Trigger output |
| cnt_o | output | 16 | Counter value |

## Verification
The checker watches four things on every cycle: the wrap to zero at the reload value, the priority of the restart, the counter holding when it is disabled, and the one-cycle relation between the internal events and `trig_o` in the restart and match-pulse modes. The following can only be shown by the bench's scenarios, which count edges from a pin change: the cycle counts through the synchroniser, the effect of polarity, the extra cycle that the alignment bit inserts, and the single clear for a held reset-mode trigger. The vector table sweeps every source code against chosen counter positions, including wraps and compare values beyond the reload value.

// File: rtl/tso_pkg.sv
package tso_pkg;
  localparam int unsigned N_CH  = 4;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned IDX_W = $clog2(N_CH);

  typedef enum logic [SEL_W-1:0] {
    TRG_RESTART = 3'd0,
    TRG_ENABLE  = 3'd1,
    TRG_UPDATE  = 3'd2,
    TRG_PULSE   = 3'd3,
    TRG_REF1    = 3'd4,
    TRG_REF2    = 3'd5,
    TRG_REF3    = 3'd6,
    TRG_REF4    = 3'd7
  } trg_sel_e;

  typedef enum logic [1:0] {
    SLV_NONE  = 2'd0,
    SLV_GATED = 2'd1,
    SLV_RESET = 2'd2,
    SLV_RSVD  = 2'd3
  } slv_mode_e;
endpackage

// File: rtl/tso_trig_in.sv
module tso_trig_in #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_trig_i,
  input  logic pol_i,
  input  logic align_i,
  output logic early_o,
  output logic eff_o,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic dly_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      dly_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_trig_i ^ pol_i};
      dly_q  <= sync_q[SYNC_STAGES-1];
      prev_q <= eff_o;
    end
  end

  assign early_o = sync_q[SYNC_STAGES-1];
  // alignment holds the internal copy back one cycle
  assign eff_o   = align_i ? dly_q : early_o;
  assign rise_o  = eff_o & ~prev_q;
endmodule

// File: rtl/tso_cnt_core.sv
module tso_cnt_core #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_CH  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       clr_i,
  input  logic [CNT_W-1:0]           arr_i,
  input  logic [N_CH-1:0][CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0]           cnt_o,
  output logic                       ovf_o,
  output logic                       hit1_o,
  output logic [N_CH-1:0]            refs_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= (cnt_q == arr_i) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign ovf_o  = en_i & (cnt_q == arr_i);
  assign hit1_o = en_i & (cnt_q == cmp_i[0]);

  for (genvar k = 0; k < N_CH; k++) begin : g_ref
    assign refs_o[k] = cnt_q < cmp_i[k];
  end
endmodule

// File: rtl/tso_trgo_mux.sv
module tso_trgo_mux
  import tso_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  trg_sel_e         sel_i,
  input  logic             restart_i,
  input  logic             enable_i,
  input  logic             update_i,
  input  logic             pulse_i,
  input  logic [N_CH-1:0]  refs_i,
  output logic             trig_o
);
  logic src;

  always_comb begin
    unique case (sel_i)
      TRG_RESTART: src = restart_i;
      TRG_ENABLE:  src = enable_i;
      TRG_UPDATE:  src = update_i;
      TRG_PULSE:   src = pulse_i;
      default:     src = refs_i[sel_i[IDX_W-1:0]];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_o <= 1'b0;
    else         trig_o <= src;
  end
endmodule

// File: rtl/tmr_sync_out.sv
module tmr_sync_out
  import tso_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sw_en_i,
  input  logic                       sw_ug_i,
  input  logic [CNT_W-1:0]           arr_i,
  input  logic [N_CH-1:0][CNT_W-1:0] cmp_i,
  input  logic [SEL_W-1:0]           mst_sel_i,
  input  logic [1:0]                 slv_mode_i,
  input  logic                       ext_pol_i,
  input  logic                       align_i,
  input  logic                       ext_trig_i,
  output logic                       trig_o,
  output logic [CNT_W-1:0]           cnt_o
);
  logic trg_early, trg_eff, trg_rise;
  logic gated, rst_mode;
  logic cnt_en, en_early, en_src, ug_evt;
  logic ovf, hit1;
  logic [N_CH-1:0] refs;
  logic [CNT_W-1:0] cnt;

  tso_trig_in #(.SYNC_STAGES(SYNC_STAGES)) u_trig_in (
    .clk_i, .rst_ni,
    .ext_trig_i,
    .pol_i   (ext_pol_i),
    .align_i,
    .early_o (trg_early),
    .eff_o   (trg_eff),
    .rise_o  (trg_rise)
  );

  assign gated    = slv_mode_e'(slv_mode_i) == SLV_GATED;
  assign rst_mode = slv_mode_e'(slv_mode_i) == SLV_RESET;
  assign cnt_en   = sw_en_i | (gated & trg_eff);
  assign en_early = sw_en_i | (gated & trg_early);
  // aligned: report the enable before the internal delay
  assign en_src   = align_i ? en_early : cnt_en;
  assign ug_evt   = sw_ug_i | (rst_mode & trg_rise);

  tso_cnt_core #(.CNT_W(CNT_W), .N_CH(N_CH)) u_cnt (
    .clk_i, .rst_ni,
    .en_i   (cnt_en),
    .clr_i  (ug_evt),
    .arr_i,
    .cmp_i,
    .cnt_o  (cnt),
    .ovf_o  (ovf),
    .hit1_o (hit1),
    .refs_o (refs)
  );

  tso_trgo_mux u_mux (
    .clk_i, .rst_ni,
    .sel_i     (trg_sel_e'(mst_sel_i)),
    .restart_i (ug_evt),
    .enable_i  (en_src),
    .update_i  (ovf | ug_evt),
    .pulse_i   (hit1),
    .refs_i    (refs),
    .trig_o
  );

  assign cnt_o = cnt;
endmodule

// File: rtl/tso_checker.sv
module tso_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] arr,
  input logic [CNT_W-1:0] cmp1,
  input logic             en,
  input logic             ug,
  input logic [2:0]       sel,
  input logic             trig
);
  assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !ug && cnt == arr) |=> cnt == '0);

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !ug) |=> $stable(cnt));

  assert_clear_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ug |=> cnt == '0);

  assert_restart_out_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == 3'd0 && ug) |=> trig);

  assert_match_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == 3'd3 && en && cnt == cmp1) |=> trig);

  assert_no_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == 3'd3 && !(en && cnt == cmp1)) |=> !trig);
endmodule

bind tmr_sync_out tso_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cnt   (cnt),
  .arr   (arr_i),
  .cmp1  (cmp_i[0]),
  .en    (cnt_en),
  .ug    (ug_evt),
  .sel   (mst_sel_i),
  .trig  (trig_o)
);

// File: tb/sim_tmr_sync_out.sv
module sim_tmr_sync_out;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sw_en = 1'b0, sw_ug = 1'b0;
  logic [15:0] arr = 16'd9;
  logic [3:0][15:0] cmp;
  logic [2:0] sel = 3'd0;
  logic [1:0] slv = 2'd0;
  logic pol = 1'b0, align = 1'b0, ext = 1'b0;
  logic trig;
  logic [15:0] cnt;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  tmr_sync_out u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sw_en_i(sw_en), .sw_ug_i(sw_ug),
    .arr_i(arr), .cmp_i(cmp), .mst_sel_i(sel), .slv_mode_i(slv),
    .ext_pol_i(pol), .align_i(align), .ext_trig_i(ext),
    .trig_o(trig), .cnt_o(cnt)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic [15:0] arr;
    logic [7:0]  n;
    logic [15:0] cnt;
    logic        trig;
  } vec_t;

  // enabled cycles n after restart; trig reflects the cycle at count n-1
  localparam vec_t VEC [15] = '{
    '{3'd4, 16'd9, 8'd3,  16'd3, 1'b1},   // R8 ch1 below
    '{3'd4, 16'd9, 8'd4,  16'd4, 1'b0},   // R8 ch1 at
    '{3'd5, 16'd9, 8'd6,  16'd6, 1'b0},   // R8 ch2
    '{3'd5, 16'd9, 8'd5,  16'd5, 1'b1},   // R8 ch2
    '{3'd6, 16'd9, 8'd8,  16'd8, 1'b0},   // R8 ch3
    '{3'd7, 16'd9, 8'd9,  16'd9, 1'b1},   // R8 ch4
    '{3'd7, 16'd9, 8'd10, 16'd0, 1'b0},   // R8 R2 wrap
    '{3'd2, 16'd9, 8'd10, 16'd0, 1'b1},   // R6 update
    '{3'd2, 16'd9, 8'd11, 16'd1, 1'b0},   // R6 after
    '{3'd3, 16'd9, 8'd4,  16'd4, 1'b1},   // R7 match
    '{3'd3, 16'd9, 8'd5,  16'd5, 1'b0},   // R7 one cycle
    '{3'd3, 16'd4, 8'd9,  16'd4, 1'b1},   // R7 repeat match
    '{3'd1, 16'd9, 8'd2,  16'd2, 1'b1},   // R5 enable
    '{3'd0, 16'd9, 8'd2,  16'd2, 1'b0},   // R4 idle
    '{3'd4, 16'd2, 8'd7,  16'd1, 1'b1}    // R8 cmp above arr
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    cmp[0] = 16'd3; cmp[1] = 16'd5; cmp[2] = 16'd7; cmp[3] = 16'd9;
    sw_en = 1'b1; sw_ug = 1'b1; ext = 1'b1;
    step(3);
    chk("R1 cnt", cnt, 0);
    chk("R1 trig", trig, 0);
    sw_en = 1'b0; sw_ug = 1'b0; ext = 1'b0;
    rst_ni = 1'b1;
    step(1);

    for (int i = 0; i < 15; i++) begin
      sel = VEC[i].sel; arr = VEC[i].arr;
      sw_en = 1'b0; sw_ug = 1'b1;
      step(1);
      sw_ug = 1'b0; sw_en = 1'b1;
      step(int'(VEC[i].n));
      chk($sformatf("R2 vec%0d cnt", i), cnt, VEC[i].cnt);
      chk($sformatf("R4-8 vec%0d trig", i), trig, VEC[i].trig);
      sw_en = 1'b0;
    end

    // R3 / R4: restart during counting, mode 0
    sel = 3'd0; arr = 16'd9; sw_en = 1'b1;
    step(5);
    sw_ug = 1'b1;
    step(1);
    chk("R3 cleared", cnt, 0);
    chk("R4 restart out", trig, 1);
    sw_ug = 1'b0;
    step(1);
    chk("R4 one cycle", trig, 0);
    chk("R3 resumes", cnt, 1);
    sw_en = 1'b0;
    step(3);
    chk("R2 hold", cnt, 1);

    // R10 gated, enable source
    sel = 3'd1; slv = 2'd1; sw_ug = 1'b1;
    step(1);
    sw_ug = 1'b0;
    step(3);
    ext = 1'b1;
    step(2);
    chk("R10 no count yet", cnt, 0);
    chk("R10 trig low", trig, 0);
    step(1);
    chk("R10 first inc", cnt, 1);
    chk("R10 trig high", trig, 1);
    ext = 1'b0;
    step(4);
    chk("R10 stopped", cnt, 3);
    chk("R10 trig low again", trig, 0);

    // R9 inverted polarity: low pin is active
    pol = 1'b1;
    step(3);
    chk("R9 inverted active", cnt, 4);
    pol = 1'b0;
    step(4);
    chk("R9 inactive freezes", cnt, 6);

    // R12 alignment
    align = 1'b1;
    step(2);
    ext = 1'b1;
    step(3);
    chk("R12 trig at E3", trig, 1);
    chk("R12 no count at E3", cnt, 6);
    step(1);
    chk("R12 first inc at E4", cnt, 7);
    ext = 1'b0;
    step(4);
    align = 1'b0;
    step(4);

    // R11 reset mode
    slv = 2'd2; sel = 3'd0; arr = 16'd99; sw_en = 1'b1; sw_ug = 1'b1;
    step(1);
    sw_ug = 1'b0;
    step(5);
    chk("R2 running", cnt, 5);
    ext = 1'b1;
    step(2);
    chk("R11 before clear", cnt, 7);
    step(1);
    chk("R11 cleared at E3", cnt, 0);
    chk("R4 delayed restart out", trig, 1);
    step(1);
    chk("R11 counts on", cnt, 1);
    chk("R4 trig drops", trig, 0);
    step(5);
    chk("R11 held level no reclear", cnt, 6);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule